// File: doc/BRIEF.md
# Multi-Domain Serial Link Reset Sequencer

This block orders the reset release of a multi-lane high-speed serial converter link. A single sequencer, running on a system clock, watches the core PLL lock, the transceiver PLL lock, a transceiver-ready status and a configuration-done handshake from the register-programming agent. It holds every reset asserted until its stage is reached. The order is: both PLLs locked, then the per-lane transceiver resets (analog first, digital after), then the control-register reset, then a configuration window, then the link and frame resets together.

The per-lane transceiver resets are active high and are driven from sequencer registers in the system clock domain. The control-register, link and frame resets are active low. Each one is passed through a two-flop synchroniser clocked by its own domain, so it asserts and deasserts on that domain's clock edges. The synchroniser flops power up at the asserted level. A loss of lock on either PLL reasserts everything and restarts the sequence. Driving `rst_ni` low re-runs the sequence from the start. The lock, ready and configuration-done inputs are expected to be synchronous to `clk_i`.

Top module: `link_rst_seq`

## Requirements
- R1: While `rst_ni` is low, `state_o` is 0 (idle), every transceiver reset bit is 1, and `csr_rst_no`, `link_rst_no` and `frame_rst_no` are 0 once three cycles of their own clocks have passed.
- R2: `state_o` uses the encoding 0 idle, 1 wait-PLL, 2 transceiver, 3 config, 4 running. After reset it moves from idle to wait-PLL on the first clock. It stays in wait-PLL, with all resets asserted, until both `core_pll_lock_i` and `xcvr_pll_lock_i` are 1.
- R3: On entering the transceiver stage, all `LANES` analog reset bits stay 1 for exactly `HOLD_CYCLES` clocks (default 16) and then all drop to 0 together.
- R4: The digital reset bits drop to 0 exactly one clock after the analog bits drop. They are never 0 while the analog bits are 1.
- R5: `csr_rst_no` releases only after the digital reset has released and `xcvr_ready_i` is 1 with both locks held. The sequencer then enters the config state (3). While `xcvr_ready_i` stays 0, the sequencer stays in state 2 with `csr_rst_no` at 0.
- R6: `link_rst_no` and `frame_rst_no` stay 0 throughout the config state. They release only after `cfg_done_i` is seen at 1 in state 3, which moves the sequencer to running (4). Running is kept after `cfg_done_i` returns to 0.
- R7: If either lock input is 0 in state 2, 3 or 4, the next clock gives `state_o` = 1 and all transceiver reset bits at 1. The domain resets then reassert, and the sequence restarts once both locks return.
- R8: When lock loss and `cfg_done_i` fall in the same cycle during the config state, lock loss wins: the sequencer goes to state 1 and `link_rst_no` and `frame_rst_no` stay 0.
- R9: Each active-low domain reset changes only through a two-flop synchroniser in its own clock. One nanosecond after the clock edge that enters running, `link_rst_no` is still 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sequencer clock |
| rst_ni | input | 1 | Global reset request, active low, asynchronous |
| csr_clk_i | input | 1 | Control-register interface clock |
| link_clk_i | input | 1 | Link clock |
| frame_clk_i | input | 1 | Frame clock |
| core_pll_lock_i | input | 1 | Core PLL lock indication |
| xcvr_pll_lock_i | input | 1 | Transceiver PLL lock indication |
| xcvr_ready_i | input | 1 | Transceiver ready status |
| cfg_done_i | input | 1 | Configuration phase complete |
| xcvr_ana_rst_o | output | LANES | Per-lane transceiver analog reset, active high |
| xcvr_dig_rst_o | output | LANES | Per-lane transceiver digital reset, active high |
| csr_rst_no | output | 1 | Control-register reset, active low, csr_clk_i domain |
| link_rst_no | output | 1 | Link reset, active low, link_clk_i domain |
| frame_rst_no | output | 1 | Frame reset, active low, frame_clk_i domain |
| state_o | output | 3 | Sequence state code |

## Verification
Lock loss and the configuration-done handshake can land in the same sequencer cycle. In that case the restart must win, and the link and frame resets must never open. The bench provokes this directly by dropping a lock on the same falling edge that raises `cfg_done_i` in the config state. It then judges the next cycle's state code and the link and frame resets after they have had time to settle. Random lock, ready and done patterns also bring the two events together. Each pattern is scored against a bench model of the settled stage.

// File: rtl/link_rst_seq_pkg.sv
package link_rst_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_WAIT_PLL = 3'd1,
    ST_XCVR     = 3'd2,
    ST_CONFIG   = 3'd3,
    ST_RUN      = 3'd4
  } seq_state_e;

  localparam int unsigned NUM_DOMAINS = 3;
  localparam int unsigned DOM_CSR   = 0;
  localparam int unsigned DOM_LINK  = 1;
  localparam int unsigned DOM_FRAME = 2;
endpackage

// File: rtl/rst_sync2.sv
// Two-flop release synchroniser; powers up asserted (low).
module rst_sync2 (
  input  logic clk_i,
  input  logic rel_i,
  output logic rst_no
);
  logic [1:0] sync_q = 2'b00;

  always_ff @(posedge clk_i) begin
    sync_q <= {sync_q[0], rel_i};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/rst_seq_fsm.sv
module rst_seq_fsm
  import link_rst_seq_pkg::*;
#(
  parameter int unsigned LANES       = 4,
  parameter int unsigned HOLD_CYCLES = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             core_pll_lock_i,
  input  logic             xcvr_pll_lock_i,
  input  logic             xcvr_ready_i,
  input  logic             cfg_done_i,
  output logic [LANES-1:0] xcvr_ana_rst_o,
  output logic [LANES-1:0] xcvr_dig_rst_o,
  output logic             csr_rel_o,
  output logic             run_rel_o,
  output logic [2:0]       state_o
);
  localparam int unsigned CNT_W = $clog2(HOLD_CYCLES + 1);
  localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_CYCLES - 1);

  seq_state_e       state_q;
  logic [CNT_W-1:0] hold_cnt_q;
  logic             ana_rel_q;
  logic             dig_rel_q;
  logic             locked;

  assign locked = core_pll_lock_i & xcvr_pll_lock_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      hold_cnt_q <= '0;
      ana_rel_q  <= 1'b0;
      dig_rel_q  <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: state_q <= ST_WAIT_PLL;
        ST_WAIT_PLL: begin
          hold_cnt_q <= '0;
          ana_rel_q  <= 1'b0;
          dig_rel_q  <= 1'b0;
          if (locked) state_q <= ST_XCVR;
        end
        ST_XCVR, ST_CONFIG, ST_RUN: begin
          if (!locked) begin
            // lock loss beats every other event
            state_q    <= ST_WAIT_PLL;
            hold_cnt_q <= '0;
            ana_rel_q  <= 1'b0;
            dig_rel_q  <= 1'b0;
          end else if (state_q == ST_XCVR) begin
            if (!ana_rel_q) begin
              hold_cnt_q <= hold_cnt_q + 1'b1;
              if (hold_cnt_q == HOLD_LAST) ana_rel_q <= 1'b1;
            end else if (!dig_rel_q) begin
              dig_rel_q <= 1'b1;
            end else if (xcvr_ready_i) begin
              state_q <= ST_CONFIG;
            end
          end else if (state_q == ST_CONFIG) begin
            if (cfg_done_i) state_q <= ST_RUN;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign xcvr_ana_rst_o = {LANES{~ana_rel_q}};
  assign xcvr_dig_rst_o = {LANES{~dig_rel_q}};
  assign csr_rel_o      = (state_q == ST_CONFIG) || (state_q == ST_RUN);
  assign run_rel_o      = (state_q == ST_RUN);
  assign state_o        = state_q;
endmodule

// File: rtl/link_rst_seq.sv
module link_rst_seq
  import link_rst_seq_pkg::*;
#(
  parameter int unsigned LANES       = 4,
  parameter int unsigned HOLD_CYCLES = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             csr_clk_i,
  input  logic             link_clk_i,
  input  logic             frame_clk_i,
  input  logic             core_pll_lock_i,
  input  logic             xcvr_pll_lock_i,
  input  logic             xcvr_ready_i,
  input  logic             cfg_done_i,
  output logic [LANES-1:0] xcvr_ana_rst_o,
  output logic [LANES-1:0] xcvr_dig_rst_o,
  output logic             csr_rst_no,
  output logic             link_rst_no,
  output logic             frame_rst_no,
  output logic [2:0]       state_o
);
  logic                   csr_rel;
  logic                   run_rel;
  logic [NUM_DOMAINS-1:0] dom_clk;
  logic [NUM_DOMAINS-1:0] dom_rel;
  logic [NUM_DOMAINS-1:0] dom_rst_n;

  rst_seq_fsm #(
    .LANES      (LANES),
    .HOLD_CYCLES(HOLD_CYCLES)
  ) u_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .core_pll_lock_i(core_pll_lock_i),
    .xcvr_pll_lock_i(xcvr_pll_lock_i),
    .xcvr_ready_i   (xcvr_ready_i),
    .cfg_done_i     (cfg_done_i),
    .xcvr_ana_rst_o (xcvr_ana_rst_o),
    .xcvr_dig_rst_o (xcvr_dig_rst_o),
    .csr_rel_o      (csr_rel),
    .run_rel_o      (run_rel),
    .state_o        (state_o)
  );

  always_comb begin
    dom_clk[DOM_CSR]   = csr_clk_i;
    dom_clk[DOM_LINK]  = link_clk_i;
    dom_clk[DOM_FRAME] = frame_clk_i;
    dom_rel[DOM_CSR]   = csr_rel;
    dom_rel[DOM_LINK]  = run_rel;
    dom_rel[DOM_FRAME] = run_rel;
  end

  for (genvar d = 0; d < NUM_DOMAINS; d++) begin : g_dom
    rst_sync2 u_sync (
      .clk_i (dom_clk[d]),
      .rel_i (dom_rel[d]),
      .rst_no(dom_rst_n[d])
    );
  end

  assign csr_rst_no   = dom_rst_n[DOM_CSR];
  assign link_rst_no  = dom_rst_n[DOM_LINK];
  assign frame_rst_no = dom_rst_n[DOM_FRAME];
endmodule

// File: rtl/link_rst_seq_chk.sv
module link_rst_seq_chk #(
  parameter int unsigned LANES       = 4,
  parameter int unsigned HOLD_CYCLES = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             core_pll_lock_i,
  input logic             xcvr_pll_lock_i,
  input logic             cfg_done_i,
  input logic [LANES-1:0] xcvr_ana_rst_o,
  input logic [LANES-1:0] xcvr_dig_rst_o,
  input logic [2:0]       state_o
);
  localparam int unsigned CW = $clog2(HOLD_CYCLES + 2);

  logic [CW-1:0] hold_seen_q;
  logic          both_lock;

  assign both_lock = core_pll_lock_i & xcvr_pll_lock_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hold_seen_q <= '0;
    else if (state_o != 3'd2) hold_seen_q <= '0;
    else if (xcvr_ana_rst_o[0] && hold_seen_q != '1) hold_seen_q <= hold_seen_q + 1'b1;
  end

  assert_state_code_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o <= 3'd4);

  assert_pll_gate_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd2 && $past(state_o) == 3'd1) |-> $past(both_lock));

  assert_lanes_agree_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(xcvr_ana_rst_o) == 0 || $countones(xcvr_ana_rst_o) == LANES) &&
    ($countones(xcvr_dig_rst_o) == 0 || $countones(xcvr_dig_rst_o) == LANES));

  assert_analog_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(xcvr_ana_rst_o[0]) && state_o == 3'd2) |-> hold_seen_q == CW'(HOLD_CYCLES));

  assert_dig_after_ana_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xcvr_dig_rst_o[0] |-> !xcvr_ana_rst_o[0]);

  assert_csr_locked_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o >= 3'd3) |-> $past(both_lock));

  assert_run_entry_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd4 && $past(state_o) != 3'd4) |-> ($past(state_o) == 3'd3 && $past(cfg_done_i)));

  assert_lock_loss_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o >= 3'd2 && !both_lock) |=> (state_o == 3'd1 && &xcvr_ana_rst_o && &xcvr_dig_rst_o));
endmodule

bind link_rst_seq link_rst_seq_chk #(
  .LANES      (LANES),
  .HOLD_CYCLES(HOLD_CYCLES)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .core_pll_lock_i(core_pll_lock_i),
  .xcvr_pll_lock_i(xcvr_pll_lock_i),
  .cfg_done_i     (cfg_done_i),
  .xcvr_ana_rst_o (xcvr_ana_rst_o),
  .xcvr_dig_rst_o (xcvr_dig_rst_o),
  .state_o        (state_o)
);

// File: tb/link_rst_seq_bench.sv
`timescale 1ns/1ps
module link_rst_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LANES      = 4;
  localparam int HOLD       = 16;
  localparam int SETTLE     = 40;

  logic clk = 0, csr_clk = 0, link_clk = 0, frame_clk = 0;
  logic rst_n = 0;
  logic core_lk = 0, xcvr_lk = 0, rdy = 0, done = 0;
  logic [LANES-1:0] ana, dig;
  logic csr_n, link_n, frame_n;
  logic [2:0] st;

  int checks = 0;
  int errors = 0;
  int model_st = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always #7 csr_clk = ~csr_clk;
  always #4 link_clk = ~link_clk;
  always #6 frame_clk = ~frame_clk;

  link_rst_seq #(.LANES(LANES), .HOLD_CYCLES(HOLD)) u_link_rst_seq (
    .clk_i(clk), .rst_ni(rst_n), .csr_clk_i(csr_clk), .link_clk_i(link_clk),
    .frame_clk_i(frame_clk), .core_pll_lock_i(core_lk), .xcvr_pll_lock_i(xcvr_lk),
    .xcvr_ready_i(rdy), .cfg_done_i(done), .xcvr_ana_rst_o(ana),
    .xcvr_dig_rst_o(dig), .csr_rst_no(csr_n), .link_rst_no(link_n),
    .frame_rst_no(frame_n), .state_o(st)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // settled stage from previous stage and held inputs
  function automatic int next_settled(int s, bit lk, bit r, bit d);
    int c;
    if (!lk) return 1;
    c = (s < 2) ? 2 : s;
    if (c == 2 && r) c = 3;
    if (c == 3 && d) c = 4;
    return c;
  endfunction

  task automatic settle_check(input string req, input int exp_st);
    repeat (SETTLE) @(negedge clk);
    chk({req, " state"}, int'(st), exp_st);
    chk({req, " analog"}, int'(ana), (exp_st <= 1) ? (1 << LANES) - 1 : 0);
    chk({req, " digital"}, int'(dig), (exp_st <= 1) ? (1 << LANES) - 1 : 0);
    chk({req, " csr_rst_n"}, int'(csr_n), (exp_st >= 3) ? 1 : 0);
    chk({req, " link_rst_n"}, int'(link_n), (exp_st == 4) ? 1 : 0);
    chk({req, " frame_rst_n"}, int'(frame_n), (exp_st == 4) ? 1 : 0);
    model_st = exp_st;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n_ana;
    process_seed();
    // R1 reset state
    repeat (5) @(negedge clk);
    chk("R1 state", int'(st), 0);
    chk("R1 analog", int'(ana), (1 << LANES) - 1);
    chk("R1 digital", int'(dig), (1 << LANES) - 1);
    chk("R1 csr_rst_n", int'(csr_n), 0);
    chk("R1 link_rst_n", int'(link_n), 0);
    chk("R1 frame_rst_n", int'(frame_n), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R2 idle to wait", int'(st), 1);
    core_lk = 1;
    settle_check("R2 one lock only", 1);

    // R3/R4 directed hold timing
    xcvr_lk = 1;
    n_ana = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (st == 3'd2 && ana != '0) n_ana++;
      else break;
    end
    chk("R3 analog hold cycles", n_ana, HOLD);
    chk("R3 analog released", int'(ana), 0);
    chk("R4 digital still held", int'(dig), (1 << LANES) - 1);
    @(negedge clk);
    chk("R4 digital released", int'(dig), 0);
    settle_check("R5 ready low", 2);

    rdy = 1;
    settle_check("R5 config", 3);

    // R9 sync latency on entry to running
    done = 1;
    @(posedge clk);
    #1;
    chk("R9 state running", int'(st), 4);
    chk("R9 link still held", int'(link_n), 0);
    settle_check("R6 running", 4);
    done = 0;
    settle_check("R6 done dropped", 4);

    // R7 lock loss
    @(negedge clk);
    core_lk = 0;
    @(negedge clk);
    chk("R7 state", int'(st), 1);
    chk("R7 analog", int'(ana), (1 << LANES) - 1);
    chk("R7 digital", int'(dig), (1 << LANES) - 1);
    settle_check("R7 settled", 1);
    core_lk = 1;
    settle_check("R7 restart", 3);

    // R8 lock loss and cfg done together
    @(negedge clk);
    done = 1;
    xcvr_lk = 0;
    @(negedge clk);
    chk("R8 state", int'(st), 1);
    settle_check("R8 link held", 1);
    xcvr_lk = 1;
    settle_check("R8 recover", 4);
    done = 0;

    // random patterns
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      core_lk = ($urandom % 4) != 0;
      xcvr_lk = ($urandom % 4) != 0;
      rdy     = $urandom % 2;
      done    = $urandom % 2;
      settle_check("R7 R8 random", next_settled(model_st, core_lk & xcvr_lk, rdy, done));
    end

    // R1 global restart
    @(negedge clk);
    rst_n = 0;
    repeat (5) @(negedge clk);
    chk("R1 restart state", int'(st), 0);
    chk("R1 restart analog", int'(ana), (1 << LANES) - 1);
    chk("R1 restart link_rst_n", int'(link_n), 0);
    core_lk = 1; xcvr_lk = 1; rdy = 1; done = 1;
    rst_n = 1;
    settle_check("R1 rerun", 4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic process_seed();
    int unsigned s;
    s = $urandom(32'h5eed_0071);
    s = s;
  endtask
endmodule